// File: doc/BRIEF.md
# Receive Error and Line Status Tracker

This block sits beside a UART's receive path. It holds the received characters in a first-in first-out store. Each stored character carries three error marks: parity, framing and break. From these marks, and from the state of the transmit side, the block builds an 8-bit line status byte. The error bits of that byte describe the character now at the head of the store.

The error bits are sticky. A clean head advances past itself when the host pops it. A flagged head keeps its bit set through later pops, until the host reads the status byte. That read wipes the stored marks from the oldest unacknowledged entry up to the present head, wrapping around the top of the store when needed. The error bits are registered, so they move only on a pop or a status read. A new character arriving at an empty store does not disturb them.

Two further bits report the transmit side. Holding-empty follows a zero transmit-queue level. Transmitter-empty additionally needs the shift register to be idle.

Top module: `line_status_unit`

## Requirements
- R1: Reset clears the store and every stored error mark. The status byte then reads 8'h60: bits 5 and 6 are 1, all other bits are 0.
- R2: Bit 0 of the status byte is 1 exactly when the receive store holds at least one character. Bits 1 and 7 are always 0.
- R3: Characters leave in arrival order, and `rx_head` shows the oldest one. A push into a full store is dropped unless a pop is accepted in the same clock. A pop of an empty store is ignored. A push and a pop in the same clock are both accepted.
- R4: Bit 2 (parity), bit 3 (framing) and bit 4 (break) are registered. After an accepted pop or a status read, they show, one clock later, the mark stored at the new tracking position for that error kind.
- R5: When the mark at the tracking position is clear, an accepted pop moves the tracking position forward by one, modulo the depth.
- R6: When the mark at the tracking position is set, pops leave the tracking position, and so the status bit, unchanged. A status read clears the marks of every entry from the tracking position through the read position after any pop in that clock. The tracking position then jumps to that read position.
- R7: When the tracking position is numerically above the read position, the clear of R6 wraps: it runs from the tracking position to the top index, then from index 0 to the read position.
- R8: When the tracking position equals the read position at a status read with a set mark, every stored mark of that kind is cleared, including those of characters not yet popped.
- R9: Bits 2 to 4 change only in a clock with an accepted pop or a status read. A push alone leaves them unchanged.
- R10: Bit 5 shows, one clock later, whether `tx_level` is zero.
- R11: Bit 6 shows, one clock later, whether `tx_level` is zero and `tx_shift_idle` is 1 at the same time.
- R12: When a push writes an entry that a status-read clear covers in the same clock, the pushed mark is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_push | input | 1 | Store a received character |
| rx_char | input | 8 | Character to store |
| rx_par_err | input | 1 | Parity error mark of the pushed character |
| rx_frm_err | input | 1 | Framing error mark of the pushed character |
| rx_brk | input | 1 | Break mark of the pushed character |
| rx_pop | input | 1 | Remove the head character |
| status_rd | input | 1 | Host reads the status byte |
| tx_level | input | 6 | Number of characters in the transmit queue |
| tx_shift_idle | input | 1 | Transmit shift register is empty |
| rx_head | output | 8 | Oldest stored character |
| status | output | 8 | Line status byte |

## Verification
The bench builds the block with its default values: a 32-entry store, 8-bit characters and a 6-bit transmit level. With that depth, a short run of push/pop pairs brings the pointers up to index 30. A flagged character can then sit at index 31 while the read position wraps to 1, which exercises the wrapped clear. The depth is also small enough to fill the store completely, so the dropped push on a full store is reached. A random phase then mixes pushes, pops and status reads at many pointer offsets, compared against the reference model every clock.

// File: rtl/lsu_pkg.sv
`timescale 1ns/1ps
package lsu_pkg;

    // status byte bit positions
    localparam int ST_READY = 0;
    localparam int ST_PAR   = 2;
    localparam int ST_FRM   = 3;
    localparam int ST_BRK   = 4;
    localparam int ST_THRE  = 5;
    localparam int ST_TEMT  = 6;

    localparam int ERR_KINDS = 3;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } err_marks_t;

    // true when idx lies in the inclusive span lo..hi, wrapping past the top;
    // an empty-looking span (lo == hi) covers the whole storage
    function automatic logic span_hit(input int idx, input int lo, input int hi);
        if (lo == hi)
            return 1'b1;
        else if (lo < hi)
            return (idx >= lo) && (idx <= hi);
        else
            return (idx >= lo) || (idx <= hi);
    endfunction

endpackage

// File: rtl/rx_char_fifo.sv
`timescale 1ns/1ps
module rx_char_fifo #(
    parameter int DEPTH = 32,
    parameter int DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [DW-1:0]                push_data,
    input  logic                         pop,
    output logic                         push_ok,
    output logic                         pop_ok,
    output logic [$clog2(DEPTH)-1:0]     wr_idx,
    output logic [$clog2(DEPTH)-1:0]     rd_next,
    output logic [DW-1:0]                head_data,
    output logic                         not_empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;

    always_comb begin
        pop_ok  = pop && (count != '0);
        push_ok = push && ((count != CW'(DEPTH)) || pop_ok);
        if (pop_ok)
            rd_next = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        else
            rd_next = rd_ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            rd_ptr <= rd_next;
            if (push_ok)
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_ptr] <= push_data;
    end

    assign wr_idx    = wr_ptr;
    assign head_data = mem[rd_ptr];
    assign not_empty = (count != '0);

    // R3: a pop on an empty store must not move the read side
    assert_empty_pop_R3: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |=> $stable(rd_ptr));

    // R3: a push into a full store with no pop leaves it full
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (count == CW'(DEPTH) && !pop) |=> (count == CW'(DEPTH)));

endmodule

// File: rtl/err_flag_track.sv
`timescale 1ns/1ps
module err_flag_track #(
    parameter int DEPTH = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [$clog2(DEPTH)-1:0]  wr_idx,
    input  logic                      wr_flag,
    input  logic                      pop_ok,
    input  logic [$clog2(DEPTH)-1:0]  rd_next,
    input  logic                      stat_rd,
    output logic                      flag_bit
);
    localparam int AW = $clog2(DEPTH);

    logic [DEPTH-1:0] flags, flags_next;
    logic [AW-1:0]    fp, fp_next;
    logic             head_set, clear_en;

    always_comb begin
        head_set = flags[fp];
        clear_en = stat_rd && head_set;
        if (pop_ok && !head_set)
            fp_next = (fp == AW'(DEPTH - 1)) ? '0 : fp + 1'b1;
        else if (clear_en)
            fp_next = rd_next;
        else
            fp_next = fp;
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_en && (wr_idx == AW'(i)))
                flags_next[i] = wr_flag;
            else if (clear_en && lsu_pkg::span_hit(i, int'(fp), int'(rd_next)))
                flags_next[i] = 1'b0;
            else
                flags_next[i] = flags[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags    <= '0;
            fp       <= '0;
            flag_bit <= 1'b0;
        end else begin
            flags <= flags_next;
            fp    <= fp_next;
            if (pop_ok || stat_rd)
                flag_bit <= flags_next[fp_next];
        end
    end

    // R9: status bit holds when neither a pop nor a status read occurs
    assert_bit_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!pop_ok && !stat_rd) |=> $stable(flag_bit));

    // R6: a clearing read with no overlapping push drops the bit
    assert_read_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (clear_en && !(wr_en && (wr_idx == rd_next))) |=> !flag_bit);

    // R6: a flagged head is not skipped by a pop
    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (pop_ok && head_set && !stat_rd) |=> $stable(fp));

    // R5: a clean head pop steps the tracking position by one
    assert_advance_R5: assert property (@(posedge clk) disable iff (rst)
        (pop_ok && !head_set && (fp != AW'(DEPTH - 1))) |=> (fp == $past(fp) + 1'b1));

endmodule

// File: rtl/tx_status_sync.sv
`timescale 1ns/1ps
module tx_status_sync #(
    parameter int TXCW = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TXCW-1:0] tx_level,
    input  logic            shift_idle,
    output logic            hold_empty,
    output logic            all_empty
);
    logic level_zero;

    assign level_zero = (tx_level == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_empty <= 1'b1;
            all_empty  <= 1'b1;
        end else begin
            hold_empty <= level_zero;
            all_empty  <= level_zero && shift_idle;
        end
    end

    // R10: holding-empty tracks the level one clock later
    assert_thre_set_R10: assert property (@(posedge clk) disable iff (rst)
        (tx_level == '0) |=> hold_empty);
    assert_thre_clr_R10: assert property (@(posedge clk) disable iff (rst)
        (tx_level != '0) |=> !hold_empty);

    // R11: transmitter-empty needs both conditions
    assert_temt_R11: assert property (@(posedge clk) disable iff (rst)
        (tx_level != '0 || !shift_idle) |=> !all_empty);

endmodule

// File: rtl/line_status_unit.sv
`timescale 1ns/1ps
module line_status_unit #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int TXCW  = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rx_push,
    input  logic [DW-1:0]   rx_char,
    input  logic            rx_par_err,
    input  logic            rx_frm_err,
    input  logic            rx_brk,
    input  logic            rx_pop,
    input  logic            status_rd,
    input  logic [TXCW-1:0] tx_level,
    input  logic            tx_shift_idle,
    output logic [DW-1:0]   rx_head,
    output logic [7:0]      status
);
    import lsu_pkg::*;

    localparam int AW = $clog2(DEPTH);

    err_marks_t                in_marks;
    logic [ERR_KINDS-1:0]      in_vec, err_bits;
    logic                      push_ok, pop_ok, not_empty;
    logic [AW-1:0]             wr_idx, rd_next;
    logic                      hold_empty, all_empty;

    assign in_marks = '{brk: rx_brk, frm: rx_frm_err, par: rx_par_err};
    assign in_vec   = in_marks;

    rx_char_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (rx_push),
        .push_data (rx_char),
        .pop       (rx_pop),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .wr_idx    (wr_idx),
        .rd_next   (rd_next),
        .head_data (rx_head),
        .not_empty (not_empty)
    );

    generate
        for (genvar k = 0; k < ERR_KINDS; k++) begin : g_err
            err_flag_track #(.DEPTH(DEPTH)) u_track (
                .clk      (clk),
                .rst      (rst),
                .wr_en    (push_ok),
                .wr_idx   (wr_idx),
                .wr_flag  (in_vec[k]),
                .pop_ok   (pop_ok),
                .rd_next  (rd_next),
                .stat_rd  (status_rd),
                .flag_bit (err_bits[k])
            );
        end
    endgenerate

    tx_status_sync #(.TXCW(TXCW)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .tx_level   (tx_level),
        .shift_idle (tx_shift_idle),
        .hold_empty (hold_empty),
        .all_empty  (all_empty)
    );

    always_comb begin
        status           = '0;
        status[ST_READY] = not_empty;
        status[ST_PAR]   = err_bits[0];
        status[ST_FRM]   = err_bits[1];
        status[ST_BRK]   = err_bits[2];
        status[ST_THRE]  = hold_empty;
        status[ST_TEMT]  = all_empty;
    end

    // R2: data-ready rises after a push into an empty store
    assert_ready_R2: assert property (@(posedge clk) disable iff (rst)
        (!not_empty && rx_push) |=> status[ST_READY]);

endmodule

// File: tb/line_status_unit_bench.sv
`timescale 1ns/1ps
module line_status_unit_bench;
    localparam int DEPTH = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       push = 1'b0, pe = 1'b0, fe = 1'b0, be = 1'b0, pop = 1'b0, srd = 1'b0;
    logic [7:0] pchar = '0;
    logic [5:0] txl = '0;
    logic       sidle = 1'b1;
    logic [7:0] rx_head, status;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    line_status_unit u_line_status_unit (
        .clk(clk), .rst(rst), .rx_push(push), .rx_char(pchar),
        .rx_par_err(pe), .rx_frm_err(fe), .rx_brk(be), .rx_pop(pop),
        .status_rd(srd), .tx_level(txl), .tx_shift_idle(sidle),
        .rx_head(rx_head), .status(status)
    );

    // ---------------- reference model ----------------
    byte unsigned q[$];
    bit  m_flag [3][DEPTH];
    int  m_fp [3];
    bit  m_bit [3];
    int  m_rd, m_wr;
    bit  m_thre, m_temt;
    bit  pok, wok, head, clr;
    int  rdn, nfp, j;
    bit  inmark [3];

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_rd = 0; m_wr = 0; m_thre = 1; m_temt = 1;
            for (int k = 0; k < 3; k++) begin
                m_fp[k] = 0; m_bit[k] = 0;
                for (int i = 0; i < DEPTH; i++) m_flag[k][i] = 0;
            end
        end else begin
            inmark[0] = pe; inmark[1] = fe; inmark[2] = be;
            pok = pop && (q.size() > 0);
            wok = push && ((q.size() < DEPTH) || pok);
            rdn = pok ? (m_rd + 1) % DEPTH : m_rd;
            for (int k = 0; k < 3; k++) begin
                head = m_flag[k][m_fp[k]];
                clr  = srd && head;
                nfp  = m_fp[k];
                if (pok && !head) nfp = (m_fp[k] + 1) % DEPTH;
                else if (clr)     nfp = rdn;
                if (clr) begin
                    if (m_fp[k] == rdn) begin
                        for (int i = 0; i < DEPTH; i++) m_flag[k][i] = 0;
                    end else begin
                        j = m_fp[k];
                        m_flag[k][j] = 0;
                        while (j != rdn) begin
                            j = (j + 1) % DEPTH;
                            m_flag[k][j] = 0;
                        end
                    end
                end
                if (wok) m_flag[k][m_wr] = inmark[k];
                if (pok || srd) m_bit[k] = m_flag[k][nfp];
                m_fp[k] = nfp;
            end
            if (pok) void'(q.pop_front());
            if (wok) begin
                q.push_back(pchar);
                m_wr = (m_wr + 1) % DEPTH;
            end
            m_rd   = rdn;
            m_thre = (txl == 0);
            m_temt = (txl == 0) && sidle;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(status[0] == (q.size() != 0), "R2 data ready", status[0], q.size() != 0);
            chk(status[1] == 0 && status[7] == 0, "R2 fixed zero bits", {status[7], status[1]}, 0);
            chk(status[4:2] == {m_bit[2], m_bit[1], m_bit[0]}, "R4/R9 error bits",
                status[4:2], {m_bit[2], m_bit[1], m_bit[0]});
            chk(status[5] == m_thre, "R10 holding empty", status[5], m_thre);
            chk(status[6] == m_temt, "R11 transmitter empty", status[6], m_temt);
            if (q.size() > 0)
                chk(rx_head == q[0], "R3 head data", rx_head, q[0]);
        end
    end

    task automatic cyc(input bit ps, input byte unsigned d, input bit [2:0] fl,
                       input bit pp, input bit sr);
        push = ps; pchar = d; {be, fe, pe} = fl; pop = pp; srd = sr;
        @(posedge clk);
        #1;
        push = 0; pop = 0; srd = 0; {be, fe, pe} = 3'b000;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(status == 8'h60, "R1 reset status", status, 8'h60);

        // R3 order, simultaneous push and pop, empty pop
        cyc(1, 8'hA1, 3'b000, 0, 0);
        chk(status[0] == 1, "R2 ready after push", status[0], 1);
        cyc(1, 8'hB2, 3'b000, 1, 0);
        chk(rx_head == 8'hB2, "R3 push with pop", rx_head, 8'hB2);
        cyc(0, 0, 3'b000, 1, 0);
        cyc(0, 0, 3'b000, 1, 0);
        cyc(1, 8'h5C, 3'b000, 0, 0);
        chk(rx_head == 8'h5C, "R3 empty pop ignored", rx_head, 8'h5C);
        cyc(0, 0, 3'b000, 1, 0);

        // R4 R6 R9 sticky parity
        cyc(1, 8'h11, 3'b000, 0, 0);
        cyc(1, 8'h22, 3'b001, 0, 0);
        chk(status[2] == 0, "R9 push leaves parity bit", status[2], 0);
        cyc(0, 0, 3'b000, 1, 0);
        chk(status[2] == 1, "R4 parity of new head", status[2], 1);
        cyc(0, 0, 3'b000, 1, 0);
        chk(status[2] == 1, "R6 parity sticky over pop", status[2], 1);
        cyc(0, 0, 3'b000, 0, 1);
        chk(status[2] == 0, "R6 read clears parity", status[2], 0);

        // R5 clean pops advance, framing
        cyc(1, 8'h31, 3'b000, 0, 0);
        cyc(1, 8'h32, 3'b000, 0, 0);
        cyc(1, 8'h33, 3'b010, 0, 0);
        cyc(0, 0, 3'b000, 1, 0);
        chk(status[3] == 0, "R5 clean head", status[3], 0);
        cyc(0, 0, 3'b000, 1, 0);
        chk(status[3] == 1, "R5 advance to framing head", status[3], 1);
        cyc(0, 0, 3'b000, 0, 1);
        cyc(0, 0, 3'b000, 1, 0);

        // R8 equal positions clear unpopped marks
        cyc(1, 8'h41, 3'b000, 0, 0);
        cyc(1, 8'h42, 3'b010, 0, 0);
        cyc(1, 8'h43, 3'b010, 0, 0);
        cyc(0, 0, 3'b000, 1, 0);
        chk(status[3] == 1, "R8 framing head", status[3], 1);
        cyc(0, 0, 3'b000, 0, 1);
        chk(status[3] == 0, "R8 read clears", status[3], 0);
        cyc(0, 0, 3'b000, 1, 0);
        chk(status[3] == 0, "R8 unpopped mark cleared", status[3], 0);
        cyc(0, 0, 3'b000, 1, 0);

        // R12 push kept over a same-clock clear
        cyc(1, 8'h51, 3'b000, 0, 0);
        cyc(1, 8'h52, 3'b100, 0, 0);
        cyc(0, 0, 3'b000, 1, 0);
        cyc(0, 0, 3'b000, 1, 0);
        chk(status[4] == 1, "R6 break sticky on empty", status[4], 1);
        cyc(1, 8'h53, 3'b100, 0, 1);
        chk(status[4] == 1, "R12 pushed break kept", status[4], 1);
        cyc(0, 0, 3'b000, 0, 1);
        chk(status[4] == 0, "R12 later read clears", status[4], 0);
        cyc(0, 0, 3'b000, 1, 0);

        // R3 full store drops extra push
        for (int i = 0; i <= DEPTH; i++) cyc(1, i[7:0], 3'b000, 0, 0);
        chk(rx_head == 8'h00, "R3 full head", rx_head, 0);
        for (int i = 0; i < DEPTH; i++) cyc(0, 0, 3'b000, 1, 0);
        chk(status[0] == 0, "R3 extra push dropped", status[0], 0);

        // R7 wrapped clear
        while (m_rd != 30) begin
            cyc(1, 8'h60, 3'b000, 0, 0);
            cyc(0, 0, 3'b000, 1, 0);
        end
        cyc(1, 8'h70, 3'b000, 0, 0);
        cyc(1, 8'h71, 3'b001, 0, 0);
        cyc(1, 8'h72, 3'b000, 0, 0);
        cyc(1, 8'h73, 3'b000, 0, 0);
        cyc(0, 0, 3'b000, 1, 0);
        chk(status[2] == 1, "R7 parity at top index", status[2], 1);
        cyc(0, 0, 3'b000, 1, 0);
        cyc(0, 0, 3'b000, 1, 0);
        chk(status[2] == 1, "R7 sticky across wrap", status[2], 1);
        cyc(0, 0, 3'b000, 0, 1);
        chk(status[2] == 0, "R7 wrapped clear", status[2], 0);
        cyc(0, 0, 3'b000, 1, 0);

        // R10 R11 transmit side
        txl = 6'd3; sidle = 1;
        cyc(0, 0, 3'b000, 0, 0);
        chk(status[6:5] == 2'b00, "R10 R11 queue busy", status[6:5], 0);
        txl = 6'd0; sidle = 0;
        cyc(0, 0, 3'b000, 0, 0);
        chk(status[6:5] == 2'b01, "R10 R11 shift busy", status[6:5], 1);
        sidle = 1;
        cyc(0, 0, 3'b000, 0, 0);
        chk(status[6:5] == 2'b11, "R11 all idle", status[6:5], 3);

        // random mix, compared every clock
        for (int i = 0; i < 3000; i++) begin
            txl   = ($urandom_range(0, 3) == 0) ? 6'($urandom_range(1, 40)) : 6'd0;
            sidle = ($urandom_range(0, 3) != 0);
            cyc($urandom_range(0, 1) == 1, 8'($urandom),
                3'($urandom_range(0, 7) & (($urandom_range(0, 2) == 0) ? 7 : 0)),
                $urandom_range(0, 2) == 0, $urandom_range(0, 5) == 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule